// File: doc/BRIEF.md
# Instruction-Cycle Watchdog with Stop Hold

This block is a supervision timer for a small controller core. A binary counter advances once per instruction cycle, as marked by a cycle-enable input. If software fails to clear it, the counter overflows and the block sends a single-clock reset request to the CPU. After that request the count starts again from zero.

Software keeps the watchdog quiet in two ways. It can issue an explicit clear instruction, or it can drive the remote carrier output high: each rising edge of that level clears the counter. While the core sits in its low-power stop state the counter is forced to zero. It counts again from zero once stop ends.

An optional prescaler lets the counter advance only once per eight enabled cycles. This serves a variant whose instruction cycle is a finer division of the oscillator.

Top module: `cyc_watchdog`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, cpu_rst_req_o is 0 and the count is zero.
- R2: The count advances by one only on a clock where cyc_en_i is 1 (with PRESCALE=1). cpu_rst_req_o goes to 1 in the clock after the 2^(STAGES-1)-th enabled cycle since the last clear. With the default STAGES=14 that is the 8192nd enabled cycle.
- R3: cpu_rst_req_o is high for exactly one clock, and the count is zero at that point. The next request comes a further 2^(STAGES-1) enabled cycles later.
- R4: A clock with wdt_clr_i=1 sets the count to zero. The next request then needs a full 2^(STAGES-1) enabled cycles after that clock.
- R5: A 0-to-1 change of remote_i clears the count in that clock. Holding remote_i at 1 clears nothing further, so a request still follows 2^(STAGES-1) enabled cycles after the rising clock.
- R6: While stop_i is 1 the count is held at zero and no request is made, whatever cyc_en_i does. After stop_i returns to 0, counting restarts from zero.
- R7: If a clear (wdt_clr_i, a remote_i rising edge or stop_i) comes in the same clock as the terminal enabled cycle, the clear wins and no request is issued.
- R8: With PRESCALE=8 the count advances once per eight enabled cycles. For STAGES=6 the first request follows 256 enabled cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_en_i | input | 1 | Instruction-cycle enable; one count opportunity per high clock |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| remote_i | input | 1 | Remote carrier output level; a rising edge clears the count |
| stop_i | input | 1 | Stop-mode state; holds the count at zero |
| cpu_rst_req_o | output | 1 | One-clock CPU reset request on overflow |

## Verification
The two functions that can fall in the same clock are the terminal count and a clear. The bench first walks the counter up to one enabled cycle short of overflow. It then applies the final enabled cycle together with wdt_clr_i, and in a later run together with a rising edge of remote_i. The expected result is that no request is issued and that the next request comes a full period later. A reference count kept in the bench sets the exact cycle of every expected request, and any pulse at any other cycle is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic hold;   // stop state: force zero
    logic clear;  // instruction or remote edge
    logic tick;   // counting opportunity
  } wdt_ctl_t;

endpackage

// File: rtl/wdt_rise_det.sv
module wdt_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int PRESCALE = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);

  localparam int DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(PRESCALE - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (en_i)      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  assign tick_o = en_i & ~restart_i & (div_q == LAST);

endmodule

// File: rtl/wdt_stage_cnt.sv
module wdt_stage_cnt
  import wdt_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wdt_ctl_t         ctl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (ctl_i.hold || ctl_i.clear) begin
        cnt_q <= '0;
      end else if (ctl_i.tick) begin
        if (&cnt_q) begin
          cnt_q <= '0;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/cyc_watchdog.sv
module cyc_watchdog
  import wdt_pkg::*;
#(
  parameter int STAGES   = 14,
  parameter int PRESCALE = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  input  logic wdt_clr_i,
  input  logic remote_i,
  input  logic stop_i,
  output logic cpu_rst_req_o
);

  // last stage is the overflow flop itself
  localparam int CNT_W = STAGES - 1;

  logic             rise;
  logic             tick;
  logic             restart;
  logic [CNT_W-1:0] cnt_q;
  wdt_ctl_t         ctl;

  wdt_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (remote_i),
    .rise_o (rise)
  );

  assign restart = stop_i | wdt_clr_i | rise;

  wdt_tick_div #(.PRESCALE(PRESCALE)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cyc_en_i),
    .restart_i (restart),
    .tick_o    (tick)
  );

  assign ctl.hold  = stop_i;
  assign ctl.clear = wdt_clr_i | rise;
  assign ctl.tick  = tick;

  wdt_stage_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .cnt_o  (cnt_q),
    .ovf_o  (cpu_rst_req_o)
  );

endmodule

// File: rtl/cyc_watchdog_chk.sv
module cyc_watchdog_chk #(
  parameter int STAGES = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_en_i,
  input logic              wdt_clr_i,
  input logic              remote_i,
  input logic              stop_i,
  input logic              cpu_rst_req_o,
  input logic [STAGES-2:0] cnt_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!cpu_rst_req_o && cnt_i == '0); // R1
    end
  end

  AST_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |=> cnt_i <= $past(cnt_i)); // R2

  AST_REQ_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_req_o |-> $past(cnt_i) == {(STAGES-1){1'b1}}); // R2

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_req_o |=> !cpu_rst_req_o); // R3

  AST_REQ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_req_o |-> cnt_i == '0); // R3

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |=> (cnt_i == '0 && !cpu_rst_req_o)); // R4 R7

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(remote_i) |=> (cnt_i == '0 && !cpu_rst_req_o)); // R5 R7

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_i == '0 && !cpu_rst_req_o)); // R6

endmodule

bind cyc_watchdog cyc_watchdog_chk #(.STAGES(STAGES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cyc_en_i      (cyc_en_i),
  .wdt_clr_i     (wdt_clr_i),
  .remote_i      (remote_i),
  .stop_i        (stop_i),
  .cpu_rst_req_o (cpu_rst_req_o),
  .cnt_i         (cnt_q)
);

// File: tb/sim_cyc_watchdog.sv
module sim_cyc_watchdog;

  localparam int TERM0 = 8191;   // 2^13 - 1 for STAGES=14

  typedef struct {
    int    at;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni;
  logic cyc_en = 1'b0, wdt_clr = 1'b0, remote = 1'b0, stop = 1'b0;
  logic req0, req1;

  always #2 clk = ~clk;

  cyc_watchdog u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_en_i(cyc_en), .wdt_clr_i(wdt_clr),
    .remote_i(remote), .stop_i(stop), .cpu_rst_req_o(req0)
  );

  cyc_watchdog #(.STAGES(6), .PRESCALE(8)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_en_i(cyc_en), .wdt_clr_i(wdt_clr),
    .remote_i(remote), .stop_i(stop), .cpu_rst_req_o(req1)
  );

  int    cyc = 0;
  int    checks = 0;
  int    bad = 0;
  int    spurious = 0;
  int    m_cnt = 0;
  bit    m_prev = 1'b0;
  bit    done = 1'b0;
  int    last_step_cyc = 0;
  int    u1_first = -1;
  string cur_tag = "R1";
  exp_t  q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // driver: one clock of stimulus, expected requests pushed to the queue
  task automatic step(bit en, bit clr, bit rem, bit stp);
    @(negedge clk);
    cyc_en = en; wdt_clr = clr; remote = rem; stop = stp;
    last_step_cyc = cyc;
    if (stp || clr || (rem && !m_prev)) m_cnt = 0;
    else if (en) begin
      if (m_cnt == TERM0) begin
        m_cnt = 0;
        q.push_back('{cyc + 1, cur_tag});
      end else m_cnt++;
    end
    m_prev = rem;
  endtask

  task automatic run_en(int n, bit rem);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, rem, 1'b0);
  endtask

  // monitor: compares every clock against the queue
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (q.size() > 0 && q[0].at == cyc) begin
        checks++;
        if (req0 !== 1'b1) begin
          bad++;
          $display("FAIL %s: cpu_rst_req_o=%0b expected 1 at cycle %0d", q[0].tag, req0, cyc);
        end
        void'(q.pop_front());
      end else if (req0 !== 1'b0) begin
        spurious++;
        bad++;
        $display("FAIL %s: cpu_rst_req_o=%0b expected 0 at cycle %0d", cur_tag, req0, cyc);
      end
      if (req1 === 1'b1 && u1_first < 0) u1_first = cyc;
    end
  end

  task automatic quiet(string tag);
    checks++;
    if (spurious != 0 || req0 !== 1'b0) begin
      bad++;
      $display("FAIL %s: unexpected requests=%0d expected 0", tag, spurious);
    end
    spurious = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: run did not finish, cycle=%0d expected < 190000", cyc);
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (req0 !== 1'b0 || req1 !== 1'b0) begin
      bad++;
      $display("FAIL R1: req0=%0b req1=%0b expected 0 0 in reset", req0, req1);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (req0 !== 1'b0) begin
      bad++;
      $display("FAIL R1: cpu_rst_req_o=%0b expected 0 after release", req0);
    end

    // R2 first overflow; R8 prescaled instance observed meanwhile
    cur_tag = "R2";
    step(1'b1, 1'b0, 1'b0, 1'b0);
    base = last_step_cyc;
    run_en(299, 1'b0);
    checks++;
    if (u1_first != base + 256) begin
      bad++;
      $display("FAIL R8: first prescaled request at %0d expected %0d", u1_first, base + 256);
    end
    run_en(8192 - 300, 1'b0);

    // R3 restart from zero after a request
    cur_tag = "R3";
    run_en(8192, 1'b0);

    // R2 sparse enable: one enabled cycle in three
    cur_tag = "R2";
    for (int i = 0; i < 8192 * 3; i++) step(i % 3 == 2, 1'b0, 1'b0, 1'b0);

    // R4 clear instruction mid-count
    cur_tag = "R4";
    run_en(5000, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    run_en(8192, 1'b0);

    // R5 rising edge clears, held level does not
    cur_tag = "R5";
    run_en(4000, 1'b0);
    run_en(10000, 1'b1);
    run_en(100, 1'b0);

    // R6 stop holds zero, then restarts from zero
    cur_tag = "R6";
    run_en(3000, 1'b0);
    for (int i = 0; i < 20000; i++) step(1'b1, 1'b0, 1'b0, 1'b1);
    quiet("R6");
    run_en(8192, 1'b0);

    // R7 clear coinciding with the terminal enabled cycle
    cur_tag = "R7";
    run_en(8191, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    run_en(8191, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    quiet("R7");
    run_en(8192, 1'b1);
    repeat (4) step(1'b0, 1'b0, 1'b0, 1'b0);

    checks++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R3: %0d expected requests never seen, expected 0 pending", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule